// File: doc/BRIEF.md
# Maskable Interrupt Latch and Vector Selector

This block gathers the maskable interrupt requests of a small 8-bit CPU core and presents the CPU with a single pending indication and the 16-bit address of the vector pair to fetch. There are three request sources:

- an external active-low request pin;
- a group of timer flag/enable pairs (two by default), which share one request;
- one periodic-interrupt flag/enable pair.

The interrupt mask bit from the CPU gates the pending output.

The pin is brought into the clock domain through a flip-flop synchronizer. A falling edge detected there sets an external request latch. The CPU's acknowledge strobe clears that latch early in servicing. Because the latch is separate from the mask, one pulse that arrives while interrupts are masked is kept and is serviced once the mask is cleared. A static parameter chooses between two trigger modes: edge-only, or edge plus a level request that lasts as long as the pin is held low. When several sources are pending together, the external request wins over the timer, and the timer wins over the periodic source.

Top module: `irq_vector_sel`

## Requirements
- R1: After reset, `pend_o` is 0, `ext_clr_o` is 0, and `vec_o` is 16'h0000 while no timer or periodic flag is enabled.
- R2: While `imask_i` is 1, `pend_o` is 0 whatever requests exist.
- R3: A falling edge on `irq_ni` sets the external latch on the third rising clock edge after the pin change. This is two synchronizer stages plus the latch. `pend_o` then rises if the mask is clear.
- R4: One low pulse of `irq_ni`, however long, sets the latch only once. In edge-only mode (`LEVEL_TRIG`=0), once acknowledged, a pin still held low raises no new request.
- R5: In level mode (`LEVEL_TRIG`=1), a synchronized low pin is a request in its own right. It is visible two clock edges after the fall, persists through acknowledge while the pin stays low, and disappears two edges after the pin returns high.
- R6: An external request selects `vec_o` = 16'h1FFA, the address of the high byte of its service address.
- R7: The timer request is active when any timer flag bit has its matching enable bit set, and then selects `vec_o` = 16'h1FF8. A flag without its enable raises nothing.
- R8: The periodic request is active when `per_flag_i` and `per_en_i` are both 1, and then selects `vec_o` = 16'h1FF6.
- R9: Priority is external, then timer, then periodic. `vec_o` always gives the highest-priority pending source, and is 16'h0000 when none is pending.
- R10: A one-cycle `ack_i` clears only the external latch. Timer and periodic requests remain until their own flag inputs drop.
- R11: A latched external request survives any time spent with `imask_i` = 1, and `pend_o` rises as soon as the mask is cleared.
- R12: `ext_clr_o` is 1 exactly in a cycle where `ack_i` is 1 and the external latch is set, and the latch is clear after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_ni | input | 1 | External request pin, active low, asynchronous |
| tmr_flag_i | input | N_TMR | Timer interrupt flags |
| tmr_en_i | input | N_TMR | Timer interrupt enables, one per flag |
| per_flag_i | input | 1 | Periodic interrupt flag |
| per_en_i | input | 1 | Periodic interrupt enable |
| imask_i | input | 1 | CPU interrupt mask bit, 1 blocks all requests |
| ack_i | input | 1 | CPU acknowledge strobe, clears the external latch |
| pend_o | output | 1 | An unmasked request is pending |
| vec_o | output | 16 | Vector address of the highest-priority pending source |
| ext_clr_o | output | 1 | External latch is being cleared this cycle |

## Verification
The checker watches the following on every cycle:

- the mask blocking `pend_o`;
- the vector chosen for each combination of active sources;
- a detected edge setting the latch and lasting only one cycle;
- the latch holding until acknowledged;
- the clear output coinciding with the latch actually being emptied.

Some properties depend on the pin waveform over many cycles, and only the directed scenarios show them. These are the exact three-edge latency from pin to latch, a long low pulse being counted once, and the difference between the two trigger modes while the pin stays low after acknowledge. A pulse taken while masked being served after unmasking also falls in this group. The bench runs an edge-mode and a level-mode instance side by side on the same stimulus.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   localparam int unsigned VEC_W = 16;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_TMR  = 2'd2,
      SRC_PER  = 2'd3
   } irq_src_e;

   localparam logic [VEC_W-1:0] VEC_NONE = '0;

endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irqv_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irqv_ext_latch.sv
module irqv_ext_latch #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          LEVEL_TRIG  = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_ni,
   input  logic ack_i,
   output logic req_o,
   output logic lat_o,
   output logic fall_o,
   output logic clr_o
);

   logic pin_sync;
   logic pin_prev_q;
   logic lat_q;

   irqv_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_ni),
      .q_o    (pin_sync)
   );

   // one extra flop gives the previous synchronized level for edge detection
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pin_prev_q <= 1'b1;
      end else begin
         pin_prev_q <= pin_sync;
      end
   end

   assign fall_o = pin_prev_q & ~pin_sync;

   // a new edge in the acknowledge cycle wins, so no pulse is lost
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lat_q <= 1'b0;
      end else begin
         lat_q <= (lat_q & ~ack_i) | fall_o;
      end
   end

   assign lat_o = lat_q;
   assign clr_o = ack_i & lat_q;

   generate
      if (LEVEL_TRIG) begin : g_level
         assign req_o = lat_q | ~pin_sync;
      end else begin : g_edge
         assign req_o = lat_q;
      end
   endgenerate

endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
   import irqv_pkg::*;
#(
   parameter int unsigned      N_TMR   = 2,
   parameter logic [VEC_W-1:0] VEC_EXT = 16'h1FFA,
   parameter logic [VEC_W-1:0] VEC_TMR = 16'h1FF8,
   parameter logic [VEC_W-1:0] VEC_PER = 16'h1FF6
) (
   input  logic             ext_req_i,
   input  logic [N_TMR-1:0] tmr_flag_i,
   input  logic [N_TMR-1:0] tmr_en_i,
   input  logic             per_flag_i,
   input  logic             per_en_i,
   output irq_src_e         src_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             any_o
);

   logic [N_TMR-1:0] tmr_hit;
   logic             tmr_req;
   logic             per_req;

   genvar gi;
   generate
      for (gi = 0; gi < N_TMR; gi++) begin : g_tmr
         assign tmr_hit[gi] = tmr_flag_i[gi] & tmr_en_i[gi];
      end
   endgenerate

   assign tmr_req = |tmr_hit;
   assign per_req = per_flag_i & per_en_i;

   always_comb begin
      if (ext_req_i) begin
         src_o = SRC_EXT;
      end else if (tmr_req) begin
         src_o = SRC_TMR;
      end else if (per_req) begin
         src_o = SRC_PER;
      end else begin
         src_o = SRC_NONE;
      end
   end

   always_comb begin
      unique case (src_o)
         SRC_EXT: vec_o = VEC_EXT;
         SRC_TMR: vec_o = VEC_TMR;
         SRC_PER: vec_o = VEC_PER;
         default: vec_o = VEC_NONE;
      endcase
   end

   assign any_o = (src_o != SRC_NONE);

endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel
   import irqv_pkg::*;
#(
   parameter int unsigned      N_TMR       = 2,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter bit               LEVEL_TRIG  = 1'b0,
   parameter logic [VEC_W-1:0] VEC_EXT     = 16'h1FFA,
   parameter logic [VEC_W-1:0] VEC_TMR     = 16'h1FF8,
   parameter logic [VEC_W-1:0] VEC_PER     = 16'h1FF6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             irq_ni,
   input  logic [N_TMR-1:0] tmr_flag_i,
   input  logic [N_TMR-1:0] tmr_en_i,
   input  logic             per_flag_i,
   input  logic             per_en_i,
   input  logic             imask_i,
   input  logic             ack_i,
   output logic             pend_o,
   output logic [15:0]      vec_o,
   output logic             ext_clr_o
);

   generate
      if (N_TMR < 1) begin : g_bad_ntmr
         $error("irq_vector_sel: N_TMR must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_vector_sel: SYNC_STAGES must be at least 2");
      end
      if (VEC_EXT == VEC_TMR || VEC_EXT == VEC_PER || VEC_TMR == VEC_PER) begin : g_bad_vec
         $error("irq_vector_sel: vector addresses must differ");
      end
      if (VEC_EXT == VEC_NONE || VEC_TMR == VEC_NONE || VEC_PER == VEC_NONE) begin : g_bad_zero
         $error("irq_vector_sel: a vector may not equal the idle value");
      end
   endgenerate

   logic     ext_req;
   logic     ext_lat_q;
   logic     ext_fall;
   logic     any_req;
   irq_src_e top_src;

   irqv_ext_latch #(
      .SYNC_STAGES (SYNC_STAGES),
      .LEVEL_TRIG  (LEVEL_TRIG)
   ) u_ext (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_ni (irq_ni),
      .ack_i  (ack_i),
      .req_o  (ext_req),
      .lat_o  (ext_lat_q),
      .fall_o (ext_fall),
      .clr_o  (ext_clr_o)
   );

   irqv_prio #(
      .N_TMR   (N_TMR),
      .VEC_EXT (VEC_EXT),
      .VEC_TMR (VEC_TMR),
      .VEC_PER (VEC_PER)
   ) u_prio (
      .ext_req_i  (ext_req),
      .tmr_flag_i (tmr_flag_i),
      .tmr_en_i   (tmr_en_i),
      .per_flag_i (per_flag_i),
      .per_en_i   (per_en_i),
      .src_o      (top_src),
      .vec_o      (vec_o),
      .any_o      (any_req)
   );

   assign pend_o = any_req & ~imask_i;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
   parameter int unsigned N_TMR   = 2,
   parameter logic [15:0] VEC_EXT = 16'h1FFA,
   parameter logic [15:0] VEC_TMR = 16'h1FF8,
   parameter logic [15:0] VEC_PER = 16'h1FF6
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [N_TMR-1:0] tmr_flag_i,
   input logic [N_TMR-1:0] tmr_en_i,
   input logic             per_flag_i,
   input logic             per_en_i,
   input logic             imask_i,
   input logic             ack_i,
   input logic             pend_o,
   input logic [15:0]      vec_o,
   input logic             ext_clr_o,
   input logic             ext_req,
   input logic             ext_lat_q,
   input logic             ext_fall
);

   logic tmr_any;
   logic per_any;
   assign tmr_any = |(tmr_flag_i & tmr_en_i);
   assign per_any = per_flag_i & per_en_i;

   AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      imask_i |-> !pend_o); // R2

   AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_fall |=> ext_lat_q); // R3

   AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_fall |=> !ext_fall); // R4

   AST_EXT_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_lat_q |-> (vec_o == VEC_EXT)); // R6

   AST_TMR_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_req && tmr_any) |-> (vec_o == VEC_TMR)); // R7

   AST_PER_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_req && !tmr_any && per_any) |-> (vec_o == VEC_PER)); // R8

   AST_IDLE_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_req && !tmr_any && !per_any) |-> (vec_o == 16'h0000 && !pend_o)); // R9

   AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_lat_q && !ack_i) |=> ext_lat_q); // R11

   AST_UNMASK_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_lat_q && !imask_i) |-> pend_o); // R11

   AST_ACK_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !ext_fall) |=> !ext_lat_q); // R10

   AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_clr_o |=> (!ext_lat_q || $past(ext_fall))); // R12

endmodule

bind irq_vector_sel irqv_checker #(
   .N_TMR   (N_TMR),
   .VEC_EXT (VEC_EXT),
   .VEC_TMR (VEC_TMR),
   .VEC_PER (VEC_PER)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .tmr_flag_i (tmr_flag_i),
   .tmr_en_i   (tmr_en_i),
   .per_flag_i (per_flag_i),
   .per_en_i   (per_en_i),
   .imask_i    (imask_i),
   .ack_i      (ack_i),
   .pend_o     (pend_o),
   .vec_o      (vec_o),
   .ext_clr_o  (ext_clr_o),
   .ext_req    (ext_req),
   .ext_lat_q  (ext_lat_q),
   .ext_fall   (ext_fall)
);

// File: tb/tb_irq_vector_sel.sv
module tb_irq_vector_sel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_n = 1'b1;
   logic [1:0]  tflag = '0;
   logic [1:0]  ten = '0;
   logic        pflag = 1'b0;
   logic        pen = 1'b0;
   logic        imask = 1'b0;
   logic        ack = 1'b0;
   logic        pend, pend_l;
   logic [15:0] vec, vec_l;
   logic        clr, clr_l;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   irq_vector_sel #(.LEVEL_TRIG(1'b0)) dut (
      .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n), .tmr_flag_i(tflag),
      .tmr_en_i(ten), .per_flag_i(pflag), .per_en_i(pen), .imask_i(imask),
      .ack_i(ack), .pend_o(pend), .vec_o(vec), .ext_clr_o(clr));

   irq_vector_sel #(.LEVEL_TRIG(1'b1)) dut_lvl (
      .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n), .tmr_flag_i(tflag),
      .tmr_en_i(ten), .per_flag_i(pflag), .per_en_i(pen), .imask_i(imask),
      .ack_i(ack), .pend_o(pend_l), .vec_o(vec_l), .ext_clr_o(clr_l));

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_irq(int low_cycles);
      irq_n = 1'b0;
      step(low_cycles);
      irq_n = 1'b1;
   endtask

   task automatic do_ack();
      ack = 1'b1;
      step(1);
      ack = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 pend after reset", {15'd0, pend}, 16'd0);
      check("R1 clr after reset", {15'd0, clr}, 16'd0);
      check("R1 vec after reset", vec, 16'h0000);
   endtask

   task automatic t_edge_basic();
      pulse_irq(2);
      check("R3 no pend before third edge", {15'd0, pend}, 16'd0);
      check("R5 level sees low pin after two edges", {15'd0, pend_l}, 16'd1);
      step(1);
      check("R3 pend after latch", {15'd0, pend}, 16'd1);
      check("R6 ext vector", vec, 16'h1FFA);
      ack = 1'b1;
      #1;
      check("R12 clr during ack", {15'd0, clr}, 16'd1);
      step(1);
      ack = 1'b0;
      check("R10 latch cleared by ack", {15'd0, pend}, 16'd0);
      check("R12 clr gone after ack", {15'd0, clr}, 16'd0);
      check("R9 idle vector", vec, 16'h0000);
   endtask

   task automatic t_long_pulse();
      irq_n = 1'b0;
      step(4);
      check("R3 long pulse latched", {15'd0, pend}, 16'd1);
      check("R5 level pend", {15'd0, pend_l}, 16'd1);
      do_ack();
      step(4);
      check("R4 held pin not recounted", {15'd0, pend}, 16'd0);
      check("R5 level persists while low", {15'd0, pend_l}, 16'd1);
      check("R5 level vector", vec_l, 16'h1FFA);
      irq_n = 1'b1;
      step(3);
      check("R5 level drops after release", {15'd0, pend_l}, 16'd0);
      check("R4 edge still idle after release", {15'd0, pend}, 16'd0);
   endtask

   task automatic t_masked();
      imask = 1'b1;
      pulse_irq(1);
      step(4);
      check("R2 mask blocks pend", {15'd0, pend}, 16'd0);
      check("R2 mask blocks level pend", {15'd0, pend_l}, 16'd0);
      check("R11 pulse kept while masked", vec, 16'h1FFA);
      step(5);
      imask = 1'b0;
      #1;
      check("R11 served after unmask", {15'd0, pend}, 16'd1);
      step(1);
      do_ack();
      check("R10 cleared after masked pulse", {15'd0, pend}, 16'd0);
   endtask

   task automatic t_timer();
      tflag = 2'b01;
      ten   = 2'b00;
      step(1);
      check("R7 flag without enable", {15'd0, pend}, 16'd0);
      ten = 2'b10;
      step(1);
      check("R7 mismatched enable", {15'd0, pend}, 16'd0);
      ten = 2'b01;
      step(1);
      check("R7 timer0 pend", {15'd0, pend}, 16'd1);
      check("R7 timer0 vector", vec, 16'h1FF8);
      tflag = 2'b10;
      ten   = 2'b10;
      step(1);
      check("R7 timer1 vector", vec, 16'h1FF8);
      tflag = 2'b00;
      step(1);
      check("R7 timer cleared", {15'd0, pend}, 16'd0);
   endtask

   task automatic t_priority();
      pflag = 1'b1;
      pen   = 1'b1;
      step(1);
      check("R8 periodic pend", {15'd0, pend}, 16'd1);
      check("R8 periodic vector", vec, 16'h1FF6);
      tflag = 2'b10;
      step(1);
      check("R9 timer over periodic", vec, 16'h1FF8);
      pulse_irq(1);
      step(3);
      check("R9 ext over timer", vec, 16'h1FFA);
      do_ack();
      check("R10 timer survives ack", vec, 16'h1FF8);
      check("R10 pend after ack", {15'd0, pend}, 16'd1);
      tflag = 2'b00;
      step(1);
      check("R10 periodic survives", vec, 16'h1FF6);
      pflag = 1'b0;
      step(1);
      check("R9 idle again", vec, 16'h0000);
      check("R9 no pend idle", {15'd0, pend}, 16'd0);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_edge_basic();
      step(3);
      t_long_pulse();
      step(3);
      t_masked();
      step(3);
      t_timer();
      t_priority();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule